// File: doc/BRIEF.md
# Turn-Model Adaptive Route Computation Unit

This unit picks the output port of a two-dimensional mesh router for one head flit. It is given the node's own column and row, the destination column and row, the direction the packet was travelling when it arrived, one congestion flag for each neighbour link, and a routing-mode code. It returns one port (local, east, west, north or south) and registers the choice one clock cycle after the head flit is presented.

Five deadlock-free modes share the same datapath. The modes are dimension order (X before Y), west-first, north-last, negative-first and odd-even. Each mode first forms the set of minimal directions that its ordering rules permit from this node. It then removes any direction that would need a forbidden turn from the arrival direction. When a legal direction in X and one in Y both remain, the congestion flags decide between them. East and north increase the column and row. West and south are the negative directions.

Top module: `rt_turn_route`

## Requirements
- R1: While reset is asserted, and until the first head flit after it, `route_valid` is 0 and `route_port` is 0 (local).
- R2: `route_valid` is high exactly in the cycle after a cycle with `head_valid` high. `route_port` then shows the choice for the inputs sampled at that edge. Without a head flit, `route_port` keeps its value. Port codes are 0 local, 1 east, 2 west, 3 north and 4 south.
- R3: When the node's coordinates equal the destination, the port is local (0).
- R4: Any non-local port reduces the distance: east only if the destination column is greater, west only if it is smaller, north only if the destination row is greater, south only if it is smaller.
- R5: Mode code 0 (dimension order) moves in X while the columns differ, and moves in Y only after that.
- R6: Mode code 1 (west-first) goes west whenever the destination lies to the west. Otherwise it may use east, north or south.
- R7: Mode code 2 (north-last) goes east or west, never north, while the packet needs both a north move and a column move.
- R8: Mode code 3 (negative-first) uses only the west and south moves it still needs while any of them remain. Only after that does it use east and north.
- R9: In mode code 4 (odd-even), a packet needing west and north may take north only in an odd column. A packet needing west and south may take south only in an even column. A packet needing east and north may take east only if a later column up to the destination is odd. A packet needing east and south may take east only if such a column is even.
- R10: The arrival direction (0 injected, 1 moving east, 2 west, 3 north, 4 south) removes the reversing direction and the turns the mode bans. Dimension order bans north/south into east/west. West-first bans north/south into west. North-last bans north into east/west. Negative-first bans north-to-west and east-to-south. Odd-even bans east-to-north and north-to-west in even columns, and east-to-south and south-to-west in odd columns. An injected packet is not restricted.
- R11: If removing banned turns would leave no direction, the unfiltered minimal set of the mode is used instead.
- R12: When one X and one Y direction are both legal, the Y direction is chosen only if the X link is congested and the Y link is not. Otherwise the X direction wins.
- R13: Mode codes 5, 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_valid | input | 1 | A head flit is presented this cycle |
| cur_x | input | COORD_W | Column of this node |
| cur_y | input | COORD_W | Row of this node |
| dst_x | input | COORD_W | Destination column |
| dst_y | input | COORD_W | Destination row |
| arrive_dir | input | 3 | Travel direction on arrival (0 injected, 1 E, 2 W, 3 N, 4 S) |
| congested | input | 4 | Link congestion flags: bit 0 E, 1 W, 2 N, 3 S |
| algo_sel | input | 3 | Routing mode code |
| route_valid | output | 1 | Registered choice is valid |
| route_port | output | 3 | Registered chosen port (0 L, 1 E, 2 W, 3 N, 4 S) |

## Verification
On a 4x4 mesh, every pair of node and destination is swept against every arrival direction and every mode code, including the three spare codes. Each pair is run under four congestion patterns. With no links congested and with all links congested, the patterns isolate the X-first tie rule. With only the X links congested, the result shows which cases offered a real choice. With only the Y links congested, it confirms that the X direction is kept. Arrival directions that no correct path of a mode can produce drive the fallback path. The distinct parities of the node and destination columns separate the odd-even rules from the plain turn bans.

// File: rtl/rt_route_pkg.sv
package rt_route_pkg;

   typedef enum logic [2:0] {
      PORT_LOCAL = 3'd0,
      PORT_EAST  = 3'd1,
      PORT_WEST  = 3'd2,
      PORT_NORTH = 3'd3,
      PORT_SOUTH = 3'd4
   } port_e;

   typedef enum logic [2:0] {
      ALG_XY         = 3'd0,
      ALG_WEST_FIRST = 3'd1,
      ALG_NORTH_LAST = 3'd2,
      ALG_NEG_FIRST  = 3'd3,
      ALG_ODD_EVEN   = 3'd4
   } alg_e;

   localparam int NUM_DIRS = 4;
   localparam int B_E = 0;
   localparam int B_W = 1;
   localparam int B_N = 2;
   localparam int B_S = 3;

   typedef logic [NUM_DIRS-1:0] dirmask_t;

   localparam dirmask_t MASK_X   = 4'b0011;
   localparam dirmask_t MASK_Y   = 4'b1100;
   localparam dirmask_t MASK_NEG = 4'b1010;

endpackage

// File: rtl/rt_route_cand.sv
module rt_route_cand
   import rt_route_pkg::*;
#(
   parameter int COORD_W = 3,
   parameter bit OE_EN   = 1'b1
) (
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   input  alg_e               alg,
   output dirmask_t           cand
);
   localparam int XW = COORD_W + 1;

   logic     go_e, go_w, go_n, go_s;
   dirmask_t need;
   dirmask_t oe_cand;

   assign go_e = dst_x > cur_x;
   assign go_w = dst_x < cur_x;
   assign go_n = dst_y > cur_y;
   assign go_s = dst_y < cur_y;
   assign need = {go_s, go_n, go_w, go_e};

   generate
      if (OE_EN) begin : g_oe
         logic [XW-1:0] next_x;
         logic          far_e, odd_ahead, even_ahead;
         assign next_x     = XW'(cur_x) + XW'(1);
         assign far_e      = XW'(dst_x) > next_x;
         assign odd_ahead  = far_e | dst_x[0];
         assign even_ahead = far_e | ~dst_x[0];
         always_comb begin
            oe_cand = need;
            if (go_e && go_n && !odd_ahead)  oe_cand[B_E] = 1'b0;
            if (go_e && go_s && !even_ahead) oe_cand[B_E] = 1'b0;
            if (go_w && go_n && !cur_x[0])   oe_cand[B_N] = 1'b0;
            if (go_w && go_s && cur_x[0])    oe_cand[B_S] = 1'b0;
         end
      end else begin : g_no_oe
         assign oe_cand = '0;
      end
   endgenerate

   always_comb begin
      case (alg)
         ALG_WEST_FIRST: cand = go_w ? dirmask_t'(1 << B_W) : need;
         ALG_NORTH_LAST: cand = (go_n && (go_e || go_w)) ? (need & MASK_X) : need;
         ALG_NEG_FIRST:  cand = (go_w || go_s) ? (need & MASK_NEG) : need;
         ALG_ODD_EVEN:   cand = oe_cand;
         default:        cand = (go_e || go_w) ? (need & MASK_X) : need;
      endcase
   end

   always_comb begin
      if (need != '0) assert (cand != '0) else $error("cand: empty set away from home");
   end

endmodule

// File: rtl/rt_route_filter.sv
module rt_route_filter
   import rt_route_pkg::*;
(
   input  logic [2:0] arrive,
   input  alg_e       alg,
   input  logic       cur_odd,
   input  dirmask_t   cand,
   output dirmask_t   legal
);
   dirmask_t ban;
   dirmask_t kept;
   logic     mv_e, mv_w, mv_n, mv_s;

   assign mv_e = arrive == 3'(PORT_EAST);
   assign mv_w = arrive == 3'(PORT_WEST);
   assign mv_n = arrive == 3'(PORT_NORTH);
   assign mv_s = arrive == 3'(PORT_SOUTH);

   always_comb begin
      ban = '0;
      if (mv_e) ban[B_W] = 1'b1;
      if (mv_w) ban[B_E] = 1'b1;
      if (mv_n) ban[B_S] = 1'b1;
      if (mv_s) ban[B_N] = 1'b1;
      case (alg)
         ALG_WEST_FIRST: if (mv_n || mv_s) ban[B_W] = 1'b1;
         ALG_NORTH_LAST: if (mv_n) ban = ban | MASK_X;
         ALG_NEG_FIRST: begin
            if (mv_n) ban[B_W] = 1'b1;
            if (mv_e) ban[B_S] = 1'b1;
         end
         ALG_ODD_EVEN: begin
            if (!cur_odd) begin
               if (mv_e) ban[B_N] = 1'b1;
               if (mv_n) ban[B_W] = 1'b1;
            end else begin
               if (mv_e) ban[B_S] = 1'b1;
               if (mv_s) ban[B_W] = 1'b1;
            end
         end
         default: if (mv_n || mv_s) ban = ban | MASK_X;
      endcase
   end

   assign kept  = cand & ~ban;
   assign legal = (kept == '0) ? cand : kept;

   always_comb begin
      assert ((legal & ~cand) == '0) else $error("filter: added a direction");
   end

endmodule

// File: rtl/rt_route_select.sv
module rt_route_select
   import rt_route_pkg::*;
(
   input  dirmask_t               legal,
   input  logic [NUM_DIRS-1:0]    congested,
   output port_e                  pick
);
   logic  has_x, has_y, busy_x, busy_y;
   port_e x_port, y_port;

   assign has_x  = |(legal & MASK_X);
   assign has_y  = |(legal & MASK_Y);
   assign x_port = legal[B_E] ? PORT_EAST : PORT_WEST;
   assign y_port = legal[B_N] ? PORT_NORTH : PORT_SOUTH;
   assign busy_x = legal[B_E] ? congested[B_E] : congested[B_W];
   assign busy_y = legal[B_N] ? congested[B_N] : congested[B_S];

   always_comb begin
      if (has_x && has_y)  pick = (busy_x && !busy_y) ? y_port : x_port;
      else if (has_x)      pick = x_port;
      else if (has_y)      pick = y_port;
      else                 pick = PORT_LOCAL;
   end

   always_comb begin
      assert ($countones(legal & MASK_X) <= 1 && $countones(legal & MASK_Y) <= 1)
         else $error("select: opposing directions both legal");
   end

endmodule

// File: rtl/rt_turn_route.sv
module rt_turn_route
   import rt_route_pkg::*;
#(
   parameter int COORD_W = 3,
   parameter bit OE_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               head_valid,
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   input  logic [2:0]         arrive_dir,
   input  logic [3:0]         congested,
   input  logic [2:0]         algo_sel,
   output logic               route_valid,
   output logic [2:0]         route_port
);
   generate
      if (COORD_W < 1 || COORD_W > 12) begin : g_bad_coord
         $error("rt_turn_route: COORD_W must lie in 1..12");
      end
   endgenerate

   alg_e     alg_eff;
   dirmask_t cand, legal;
   port_e    pick;
   logic     valid_q;
   logic [2:0] port_q;

   always_comb begin
      if (algo_sel == 3'(ALG_ODD_EVEN) && OE_EN) alg_eff = ALG_ODD_EVEN;
      else if (algo_sel < 3'(ALG_ODD_EVEN))       alg_eff = alg_e'(algo_sel);
      else                                        alg_eff = ALG_XY;
   end

   rt_route_cand #(.COORD_W(COORD_W), .OE_EN(OE_EN)) i_cand (
      .cur_x (cur_x),
      .cur_y (cur_y),
      .dst_x (dst_x),
      .dst_y (dst_y),
      .alg   (alg_eff),
      .cand  (cand)
   );

   rt_route_filter i_filter (
      .arrive  (arrive_dir),
      .alg     (alg_eff),
      .cur_odd (cur_x[0]),
      .cand    (cand),
      .legal   (legal)
   );

   rt_route_select i_select (
      .legal     (legal),
      .congested (congested),
      .pick      (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         port_q  <= 3'(PORT_LOCAL);
      end else begin
         valid_q <= head_valid;
         if (head_valid) port_q <= pick;
      end
   end

   assign route_valid = valid_q;
   assign route_port  = port_q;

   p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> $past(head_valid));

   p_local_home_r3: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> ((route_port == 3'(PORT_LOCAL)) ==
                       ($past(cur_x) == $past(dst_x) && $past(cur_y) == $past(dst_y))));

   p_minimal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |->
         (route_port != 3'(PORT_EAST)  || $past(dst_x) > $past(cur_x)) &&
         (route_port != 3'(PORT_WEST)  || $past(dst_x) < $past(cur_x)) &&
         (route_port != 3'(PORT_NORTH) || $past(dst_y) > $past(cur_y)) &&
         (route_port != 3'(PORT_SOUTH) || $past(dst_y) < $past(cur_y)));

   p_x_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid && $past(alg_eff == ALG_XY) && $past(cur_x != dst_x) |->
         (route_port == 3'(PORT_EAST) || route_port == 3'(PORT_WEST)));

   p_west_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid && $past(alg_eff == ALG_WEST_FIRST) && $past(dst_x < cur_x) |->
         route_port == 3'(PORT_WEST));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(head_valid) |-> !route_valid && $stable(route_port));

endmodule

// File: tb/test_rt_turn_route.sv
`timescale 1ns/1ps
module test_rt_turn_route;
   localparam int CW = 2;
   localparam int SPAN = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          head_valid = 1'b0;
   logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
   logic [2:0]    arrive_dir = '0;
   logic [3:0]    congested = '0;
   logic [2:0]    algo_sel = '0;
   logic          route_valid;
   logic [2:0]    route_port;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rt_turn_route #(.COORD_W(CW), .OE_EN(1'b1)) i_rt_turn_route (
      .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
      .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
      .arrive_dir(arrive_dir), .congested(congested), .algo_sel(algo_sel),
      .route_valid(route_valid), .route_port(route_port)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected port from the requirements: 0 L, 1 E, 2 W, 3 N, 4 S; masks bit0 E, bit1 W, bit2 N, bit3 S
   task automatic model(input int cx, input int cy, input int dx, input int dy,
                        input int arr, input int alg, input int cg,
                        output int port, output string tag);
      int a, need, cand, ban, filt, leg, xp, yp;
      bit ne, nw, nn, ns, fb, two, xb, yb;
      a  = (alg > 4) ? 0 : alg;
      ne = dx > cx; nw = dx < cx; nn = dy > cy; ns = dy < cy;
      need = int'(ne) | (int'(nw) << 1) | (int'(nn) << 2) | (int'(ns) << 3);
      case (a)
         0: cand = (ne || nw) ? (need & 3) : need;
         1: cand = nw ? 2 : need;
         2: cand = (nn && (ne || nw)) ? (need & 3) : need;
         3: cand = (nw || ns) ? (need & 10) : need;
         default: begin
            cand = need;
            if (ne && nn && !(dx > cx + 1 || dx % 2 == 1)) cand &= ~1;
            if (ne && ns && !(dx > cx + 1 || dx % 2 == 0)) cand &= ~1;
            if (nw && nn && cx % 2 == 0) cand &= ~4;
            if (nw && ns && cx % 2 == 1) cand &= ~8;
         end
      endcase
      ban = 0;
      if (arr == 1) ban |= 2;
      if (arr == 2) ban |= 1;
      if (arr == 3) ban |= 8;
      if (arr == 4) ban |= 4;
      case (a)
         0: if (arr == 3 || arr == 4) ban |= 3;
         1: if (arr == 3 || arr == 4) ban |= 2;
         2: if (arr == 3) ban |= 3;
         3: begin if (arr == 3) ban |= 2; if (arr == 1) ban |= 8; end
         default: begin
            if (cx % 2 == 0) begin if (arr == 1) ban |= 4; if (arr == 3) ban |= 2; end
            else begin if (arr == 1) ban |= 8; if (arr == 4) ban |= 2; end
         end
      endcase
      filt = cand & ~ban;
      fb   = (filt == 0) && (cand != 0);
      leg  = (filt == 0) ? cand : filt;
      two  = ((leg & 3) != 0) && ((leg & 12) != 0);
      xp = ((leg & 1) != 0) ? 1 : 2;
      yp = ((leg & 4) != 0) ? 3 : 4;
      xb = (xp == 1) ? cg[0] : cg[1];
      yb = (yp == 3) ? cg[2] : cg[3];
      if (two)               port = (xb && !yb) ? yp : xp;
      else if ((leg & 3) != 0)  port = xp;
      else if ((leg & 12) != 0) port = yp;
      else                   port = 0;
      if (need == 0)                   tag = "R3";
      else if (fb)                     tag = "R11";
      else if (two)                    tag = "R12";
      else if ((cand & ban) != 0)      tag = "R10";
      else if (alg > 4)                tag = "R13";
      else begin
         case (a)
            0: tag = "R5";
            1: tag = "R6";
            2: tag = "R7";
            3: tag = "R8";
            default: tag = "R9";
         endcase
      end
   endtask

   function automatic int minimal_ok(input int p, input int cx, input int cy,
                                     input int dx, input int dy);
      case (p)
         0: return int'(cx == dx && cy == dy);
         1: return int'(dx > cx);
         2: return int'(dx < cx);
         3: return int'(dy > cy);
         4: return int'(dy < cy);
         default: return 0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int cps[4] = '{0, 15, 3, 12};
      int exp_p, last_p;
      string tag;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(route_valid), 0);
      check("R1 port in reset", int'(route_port), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", int'(route_valid), 0);
      check("R1 port after reset", int'(route_port), 0);

      for (int alg = 0; alg < 8; alg++)
         for (int arr = 0; arr < 5; arr++)
            for (int ci = 0; ci < 4; ci++)
               for (int cx = 0; cx < SPAN; cx++)
                  for (int cy = 0; cy < SPAN; cy++)
                     for (int dx = 0; dx < SPAN; dx++)
                        for (int dy = 0; dy < SPAN; dy++) begin
                           head_valid = 1'b1;
                           cur_x = CW'(cx); cur_y = CW'(cy);
                           dst_x = CW'(dx); dst_y = CW'(dy);
                           arrive_dir = 3'(arr); algo_sel = 3'(alg);
                           congested = 4'(cps[ci]);
                           model(cx, cy, dx, dy, arr, alg, cps[ci], exp_p, tag);
                           @(negedge clk);
                           check("R2 valid", int'(route_valid), 1);
                           check(tag, int'(route_port), exp_p);
                           check("R4 minimal", minimal_ok(int'(route_port), cx, cy, dx, dy), 1);
                        end

      // R2: with no head flit the output holds
      last_p = int'(route_port);
      head_valid = 1'b0;
      cur_x = 0; cur_y = 0; dst_x = 3; dst_y = 3; arrive_dir = 0; algo_sel = 0; congested = 0;
      repeat (3) begin
         @(negedge clk);
         check("R2 idle valid", int'(route_valid), 0);
         check("R2 idle hold", int'(route_port), last_p);
      end
      head_valid = 1'b1;
      @(negedge clk);
      head_valid = 1'b0;
      check("R2 head valid", int'(route_valid), 1);
      check("R5 head port", int'(route_port), 1);
      @(negedge clk);
      check("R2 one-cycle valid", int'(route_valid), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule